// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a one-cycle request into the series of byte-wide write cycles that a JEDEC-style parallel NOR flash expects before it will act on a command. The requester gives an opcode, a base address for the device, a sector address (used only by sector erase) and a device-variant bit. The block expands the opcode into its unlock prefix, command bytes and target addresses. It then plays each write out on an asynchronous bus with a single master: address, data out, active-low write-enable and active-low chip-enable. The setup time and the write-enable pulse width are parameters.

The variant bit picks which pair of unlock addresses is used. With the wide variant the pair is base+0xAAA and then base+0x555. With the narrow variant it is base+0x555 and then base+0x2AA. The erase commands repeat the unlock before their final byte. The block raises busy from the cycle after it takes a request and drops it again, together with a one-cycle done pulse, once the last write's hold cycle has finished. An opcode it does not know is answered at once with done and an error flag, and no bus traffic. Polling the device for completion and reading data back are left to other logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy, done and err are 0, and bus_we_n and bus_ce_n are 1.
- R2: An unlock prefix is two writes, 0xAA and then 0x55. With variant=0 they go to base+0xAAA and then base+0x555. With variant=1 they go to base+0x555 and then base+0x2AA. Below, "first unlock address" means the first address of that pair.
- R3: Opcode 0 (reset) is an unlock followed by 0xF0 to the first unlock address. Opcode 1 (autoselect) is an unlock followed by 0x90 there. Opcode 4 (bypass entry) is an unlock followed by 0x20 there.
- R4: Opcode 2 (sector erase) is an unlock, then 0x80 to the first unlock address, then a second unlock, then 0x30 to the sector address.
- R5: Opcode 3 (chip erase) is an unlock, then 0x80 to the first unlock address, then a second unlock, then 0x10 to the base address.
- R6: Opcode 5 (bypass exit) is 0x90 and then 0x00, both to the base address, with no unlock prefix.
- R7: Each write shows its address and data with bus_ce_n low and bus_we_n high for SETUP_CYC cycles. bus_we_n is then low for exactly WE_CYC cycles. One more cycle follows with bus_we_n high and the address and data unchanged.
- R8: A request is taken on a clock edge where req_valid is 1 and busy is 0. busy is 1 from the next cycle, and the first write's setup starts in that same cycle. A request that arrives while busy is 1 is ignored.
- R9: In the cycle after the hold cycle of the final write, done is 1 for one cycle, busy is 0 and bus_ce_n is 1.
- R10: Opcodes 6 and 7 give done=1 and err=1 in the cycle after the request. No write-enable pulse is issued, bus_ce_n stays high and busy stays 0.
- R11: err is 0 whenever done ends a valid opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Opcode (0 reset, 1 autoselect, 2 sector erase, 3 chip erase, 4 bypass entry, 5 bypass exit) |
| req_base | input | ADDR_W | Device base address |
| req_sector | input | ADDR_W | Target sector address for sector erase |
| req_narrow | input | 1 | Variant: 0 for wide unlock addresses, 1 for narrow |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown opcode, valid with done |
| bus_addr | output | ADDR_W | Flash address |
| bus_dout | output | 8 | Flash write data |
| bus_we_n | output | 1 | Active-low write-enable |
| bus_ce_n | output | 1 | Active-low chip-enable |

## Verification
A request taken on edge k shows its first setup cycle right after edge k. Each write then takes SETUP_CYC+WE_CYC+1 cycles, so done falls due exactly N*(SETUP_CYC+WE_CYC+1) cycles after the request for an N-write opcode. An unknown opcode answers one cycle after the request. The bench works out this cycle-by-cycle waveform from the requirements and compares every cycle at the falling clock edge, after the registers have settled: busy, done, chip-enable, write-enable, address and data. A request injected during a sequence must leave that waveform unchanged and must not start a new one after done.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    // opcode values seen on req_op
    localparam logic [2:0] OPC_RESET   = 3'd0;
    localparam logic [2:0] OPC_AUTOSEL = 3'd1;
    localparam logic [2:0] OPC_SECTER  = 3'd2;
    localparam logic [2:0] OPC_CHIPER  = 3'd3;
    localparam logic [2:0] OPC_BYPIN   = 3'd4;
    localparam logic [2:0] OPC_BYPOUT  = 3'd5;

    // bytes placed on the data bus
    localparam logic [7:0] BYTE_KEY1    = 8'hAA;
    localparam logic [7:0] BYTE_KEY2    = 8'h55;
    localparam logic [7:0] BYTE_RESET   = 8'hF0;
    localparam logic [7:0] BYTE_IDENT   = 8'h90;
    localparam logic [7:0] BYTE_ERSETUP = 8'h80;
    localparam logic [7:0] BYTE_SECTER  = 8'h30;
    localparam logic [7:0] BYTE_CHIPER  = 8'h10;
    localparam logic [7:0] BYTE_BYPIN   = 8'h20;
    localparam logic [7:0] BYTE_ZERO    = 8'h00;

    // unlock offsets per variant
    localparam logic [11:0] OFS_WIDE_A = 12'hAAA;
    localparam logic [11:0] OFS_WIDE_B = 12'h555;
    localparam logic [11:0] OFS_NARR_A = 12'h555;
    localparam logic [11:0] OFS_NARR_B = 12'h2AA;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } wr_phase_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/nor_seq_step.sv
module nor_seq_step
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [2:0]        op,
    input  logic [2:0]        step,
    input  logic              narrow,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] sector,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic [2:0]        last_idx,
    output logic              op_ok
);

    logic [ADDR_W-1:0] key_a;
    logic [ADDR_W-1:0] key_b;
    logic [7:0]        short_cmd;

    // variant selects the unlock address pair
    generate
        if (ADDR_W >= 12) begin : g_ofs
            always_comb begin
                key_a = base + (narrow ? ADDR_W'(OFS_NARR_A) : ADDR_W'(OFS_WIDE_A));
                key_b = base + (narrow ? ADDR_W'(OFS_NARR_B) : ADDR_W'(OFS_WIDE_B));
            end
        end else begin : g_ofs_small
            always_comb begin
                key_a = base + (narrow ? OFS_NARR_A[ADDR_W-1:0] : OFS_WIDE_A[ADDR_W-1:0]);
                key_b = base + (narrow ? OFS_NARR_B[ADDR_W-1:0] : OFS_WIDE_B[ADDR_W-1:0]);
            end
        end
    endgenerate

    always_comb begin
        case (op)
            OPC_RESET:   short_cmd = BYTE_RESET;
            OPC_AUTOSEL: short_cmd = BYTE_IDENT;
            default:     short_cmd = BYTE_BYPIN;
        endcase
    end

    always_comb begin
        addr     = base;
        data     = BYTE_ZERO;
        last_idx = 3'd0;
        op_ok    = 1'b1;
        case (op)
            OPC_RESET, OPC_AUTOSEL, OPC_BYPIN: begin
                last_idx = 3'd2;
                case (step)
                    3'd0:    begin addr = key_a; data = BYTE_KEY1; end
                    3'd1:    begin addr = key_b; data = BYTE_KEY2; end
                    default: begin addr = key_a; data = short_cmd; end
                endcase
            end
            OPC_SECTER, OPC_CHIPER: begin
                last_idx = 3'd5;
                case (step)
                    3'd0, 3'd3: begin addr = key_a; data = BYTE_KEY1; end
                    3'd1, 3'd4: begin addr = key_b; data = BYTE_KEY2; end
                    3'd2:       begin addr = key_a; data = BYTE_ERSETUP; end
                    default: begin
                        if (op == OPC_SECTER) begin
                            addr = sector;
                            data = BYTE_SECTER;
                        end else begin
                            addr = base;
                            data = BYTE_CHIPER;
                        end
                    end
                endcase
            end
            OPC_BYPOUT: begin
                last_idx = 3'd1;
                addr     = base;
                data     = (step == 3'd0) ? BYTE_IDENT : BYTE_ZERO;
            end
            default: begin
                op_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nor_wr_phase.sv
module nor_wr_phase
    import nor_seq_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic we_n,
    output logic in_hold
);

    localparam int MAXC = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    typedef struct packed {
        wr_phase_e     ph;
        logic [CW-1:0] cnt;
        logic          we_n;
    } ph_state_t;

    ph_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_SETUP;
                    s_d.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == CW'(SETUP_CYC - 1)) begin
                    s_d.ph  = PH_PULSE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_PULSE: begin
                if (s_q.cnt == CW'(WE_CYC - 1)) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.ph  = start ? PH_SETUP : PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
        s_d.we_n = (s_d.ph != PH_PULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.cnt  <= '0;
            s_q.we_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign we_n    = s_q.we_n;
    assign in_hold = (s_q.ph == PH_HOLD);

    // R7
    start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (s_q.ph == PH_IDLE || s_q.ph == PH_HOLD));

    // R7
    hold_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ph == PH_HOLD) |-> $past(s_q.ph) == PH_PULSE);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_sector,
    input  logic              req_narrow,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    output logic              bus_we_n,
    output logic              bus_ce_n
);

    localparam int LCW = $clog2(WE_CYC + 2);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        op;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] sector;
        logic              narrow;
        logic [2:0]        step;
        logic [2:0]        last;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              ce_n;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic              idle_q;
    logic [2:0]        dec_op;
    logic [2:0]        dec_step;
    logic              dec_narrow;
    logic [ADDR_W-1:0] dec_base;
    logic [ADDR_W-1:0] dec_sector;
    logic [ADDR_W-1:0] dec_addr;
    logic [7:0]        dec_data;
    logic [2:0]        dec_last;
    logic              dec_ok;
    logic              wr_start;
    logic              wr_hold;
    logic              wr_we_n;

    assign idle_q = (q.st == SQ_IDLE);

    // decode the incoming request while idle, the latched one while running
    always_comb begin
        dec_op     = idle_q ? req_op     : q.op;
        dec_narrow = idle_q ? req_narrow : q.narrow;
        dec_base   = idle_q ? req_base   : q.base;
        dec_sector = idle_q ? req_sector : q.sector;
        dec_step   = idle_q ? 3'd0       : 3'(q.step + 3'd1);
    end

    nor_seq_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .op       (dec_op),
        .step     (dec_step),
        .narrow   (dec_narrow),
        .base     (dec_base),
        .sector   (dec_sector),
        .addr     (dec_addr),
        .data     (dec_data),
        .last_idx (dec_last),
        .op_ok    (dec_ok)
    );

    nor_wr_phase #(
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_start),
        .we_n    (wr_we_n),
        .in_hold (wr_hold)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        wr_start = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    if (!dec_ok) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st     = SQ_RUN;
                        d.op     = req_op;
                        d.base   = req_base;
                        d.sector = req_sector;
                        d.narrow = req_narrow;
                        d.step   = 3'd0;
                        d.last   = dec_last;
                        d.addr   = dec_addr;
                        d.data   = dec_data;
                        d.ce_n   = 1'b0;
                        wr_start = 1'b1;
                    end
                end
            end
            default: begin
                if (wr_hold) begin
                    if (q.step == q.last) begin
                        d.st   = SQ_IDLE;
                        d.ce_n = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.step   = 3'(q.step + 3'd1);
                        d.addr   = dec_addr;
                        d.data   = dec_data;
                        wr_start = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= SQ_IDLE;
            q.op     <= '0;
            q.base   <= '0;
            q.sector <= '0;
            q.narrow <= 1'b0;
            q.step   <= '0;
            q.last   <= '0;
            q.addr   <= '0;
            q.data   <= '0;
            q.ce_n   <= 1'b1;
            q.done   <= 1'b0;
            q.err    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st == SQ_RUN);
    assign done     = q.done;
    assign err      = q.err;
    assign bus_addr = q.addr;
    assign bus_dout = q.data;
    assign bus_ce_n = q.ce_n;
    assign bus_we_n = wr_we_n;

    // length of the current write-enable pulse, for the width check
    logic [LCW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!bus_we_n) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // R7
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> !bus_ce_n);

    // R7
    pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> ($stable(bus_addr) && $stable(bus_dout)));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_dout) && !bus_ce_n));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> (low_cnt_q == LCW'(WE_CYC)));

    // R8
    busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && bus_ce_n));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;

    localparam int AW = 24;
    localparam int SC = 2;
    localparam int WC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_sector = '0;
    logic          req_narrow = 1'b0;
    logic          busy, done, err, bus_we_n, bus_ce_n;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_dout;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [AW-1:0] ea [6];
    logic [7:0]    ed [6];
    int            en;

    always #5 clk = ~clk;

    nor_cmd_seq #(
        .ADDR_W    (AW),
        .SETUP_CYC (SC),
        .WE_CYC    (WC)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_base   (req_base),
        .req_sector (req_sector),
        .req_narrow (req_narrow),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_we_n   (bus_we_n),
        .bus_ce_n   (bus_ce_n)
    );

    function automatic logic [63:0] pack_obs(logic b, logic dn, logic e, logic c,
                                             logic w, logic [AW-1:0] a, logic [7:0] dt);
        return 64'({b, dn, e, c, w, a, dt});
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (busy,done,err,ce_n,we_n,addr,data)",
                     tag, act, exp);
        end
    endtask

    // expected write list from the requirements (R2..R6)
    task automatic build(input logic [2:0] op, input logic [AW-1:0] base,
                         input logic [AW-1:0] sec, input logic nar);
        logic [AW-1:0] ka, kb;
        ka = base + (nar ? AW'(12'h555) : AW'(12'hAAA));
        kb = base + (nar ? AW'(12'h2AA) : AW'(12'h555));
        case (op)
            3'd0, 3'd1, 3'd4: begin
                en = 3;
                ea[0] = ka; ed[0] = 8'hAA;
                ea[1] = kb; ed[1] = 8'h55;
                ea[2] = ka;
                ed[2] = (op == 3'd0) ? 8'hF0 : (op == 3'd1) ? 8'h90 : 8'h20;
            end
            3'd2, 3'd3: begin
                en = 6;
                ea[0] = ka; ed[0] = 8'hAA;
                ea[1] = kb; ed[1] = 8'h55;
                ea[2] = ka; ed[2] = 8'h80;
                ea[3] = ka; ed[3] = 8'hAA;
                ea[4] = kb; ed[4] = 8'h55;
                ea[5] = (op == 3'd2) ? sec : base;
                ed[5] = (op == 3'd2) ? 8'h30 : 8'h10;
            end
            default: begin
                en = 2;
                ea[0] = base; ed[0] = 8'h90;
                ea[1] = base; ed[1] = 8'h00;
            end
        endcase
    endtask

    // issue one request and compare every cycle until done
    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] base,
                          input logic [AW-1:0] sec, input logic nar,
                          input bit intrude, input string tag);
        logic [63:0] act, exp;
        build(op, base, sec, nar);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base;
        req_sector = sec; req_narrow = nar;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < en; w++) begin
            for (int c = 0; c < SC + WC + 1; c++) begin
                logic ew;
                ew = (c >= SC && c < SC + WC) ? 1'b0 : 1'b1;
                act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, bus_addr, bus_dout);
                exp = pack_obs(1'b1, 1'b0, 1'b0, 1'b0, ew, ea[w], ed[w]);
                chk(act == exp, $sformatf("%s R7 write %0d cycle %0d", tag, w, c), act, exp);
                if (intrude && w == 0 && c == 1) begin
                    req_valid = 1'b1; req_op = 3'd5; req_base = 24'h0F0F00;
                end else begin
                    req_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, bus_addr, bus_dout);
        exp = pack_obs(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ea[en-1], ed[en-1]);
        chk(act == exp, {tag, " R9 R11 done pulse"}, act, exp);
        @(negedge clk);
        act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, bus_addr, bus_dout);
        exp = pack_obs(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ea[en-1], ed[en-1]);
        chk(act == exp, {tag, " R9 R8 idle after done"}, act, exp);
    endtask

    task automatic t_reset_state;
        logic [63:0] act, exp;
        act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, '0, '0);
        exp = pack_obs(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, '0);
        chk(act == exp, "R1 reset state", act, exp);
    endtask

    task automatic t_short_cmds;
        run_op(3'd0, 24'h000000, 24'h0, 1'b0, 1'b0, "R3 R2 reset-cmd wide");
        run_op(3'd1, 24'h100000, 24'h0, 1'b1, 1'b0, "R3 R2 autoselect narrow");
        run_op(3'd4, 24'h200000, 24'h0, 1'b0, 1'b0, "R3 bypass entry wide");
    endtask

    task automatic t_erases;
        run_op(3'd2, 24'h080000, 24'h0A0000, 1'b1, 1'b0, "R4 sector erase narrow");
        run_op(3'd3, 24'h300000, 24'h3F0000, 1'b0, 1'b0, "R5 chip erase wide");
    endtask

    task automatic t_bypass_exit;
        run_op(3'd5, 24'h400000, 24'h0, 1'b1, 1'b0, "R6 bypass exit");
    endtask

    task automatic t_ignore_busy;
        run_op(3'd2, 24'h010000, 24'h050000, 1'b0, 1'b1, "R8 request while busy");
    endtask

    task automatic t_unknown;
        logic [63:0] act, exp;
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'(k); req_base = 24'h123000;
            @(negedge clk);
            req_valid = 1'b0;
            act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, '0, '0);
            exp = pack_obs(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
            chk(act == exp, $sformatf("R10 unknown op %0d response", k), act, exp);
            @(negedge clk);
            act = pack_obs(busy, done, err, bus_ce_n, bus_we_n, '0, '0);
            exp = pack_obs(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, '0);
            chk(act == exp, $sformatf("R10 unknown op %0d no bus cycle", k), act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_short_cmds();
        t_erases();
        t_bypass_exit();
        t_ignore_busy();
        t_unknown();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule